// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of conditional branches by running two predictors side by side and letting a trained chooser pick between them. The global side keeps one shift register of recent branch outcomes. That register indexes a table of two-bit counters directly. The local side keeps a table of per-branch outcome histories, selected by PC bits. The history read from that table then indexes a second table of two-bit counters. A chooser table uses the same global history as its index and decides which of the two sides supplies the final answer.

A fetch stage presents a PC on the predict port. Two cycles later the block returns the final direction. With it come all three counter values and both histories that were used. The fetch stage carries these values with the branch and returns them on the update port when the branch resolves, together with the real outcome. The block folds its own prediction into the global history as soon as the prediction leaves it. A resolved branch whose outcome differs from the prediction rebuilds the global history from the returned snapshot. After reset the block clears its tables by itself and raises a ready flag when it is done.

Top module: `tourney_bp`

## Requirements
- R1: While reset is held and for one cycle per entry of the largest table afterwards, `ready_o` is 0. After that it stays 1 until the next reset. At that point every counter in all three tables holds 2'b01 (weakly not-taken), every local history is 0 and the global history is 0.
- R2: A request taken while `ready_o` is 1 produces exactly one result with `pred_valid_o` high two clock edges after the edge that accepted it. A request made while `ready_o` is 0 produces no result.
- R3: When the chooser counter's MSB is 1, the final direction is the global counter's MSB. Otherwise it is the local counter's MSB. A direction bit of 1 means taken.
- R4: The global counter and the chooser counter are both read at the current 12-bit global history, whatever the PC.
- R5: The local history is read at entry `pc[11:2]` of the 1024-entry history table. The local counter is read at that 10-bit history in the 1024-entry local counter table.
- R6: On update, the global counter at the returned global history moves one step toward the outcome and saturates at 0 and 3. The local counter at the returned local history does the same.
- R7: On update, the chooser counter at the returned global history changes only when the MSBs of the returned global and local counters differ. It then steps up (saturating at 3) if the global side matched the outcome, and down (saturating at 0) if the local side matched.
- R8: One edge after a result leaves the block, the global history becomes `{old[10:0], pred_taken_o}`. `pred_ghist_o` and `pred_lhist_o` report the histories used for that result.
- R9: An update whose outcome differs from the final direction implied by the returned counters sets the global history to `{upd_ghist_i[10:0], upd_taken_i}`. This repair wins over a speculative shift on the same edge.
- R10: On update, entry `upd_pc_i[11:2]` of the local history table becomes `{upd_lhist_i[8:0], upd_taken_i}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_o | output | 1 | Table clearing finished, requests accepted |
| pred_valid_i | input | 1 | Prediction request |
| pred_pc_i | input | 32 | PC of the branch to predict |
| pred_valid_o | output | 1 | Result valid |
| pred_taken_o | output | 1 | Final direction (1 = taken) |
| pred_gctr_o | output | 2 | Global counter used |
| pred_lctr_o | output | 2 | Local counter used |
| pred_cctr_o | output | 2 | Chooser counter used |
| pred_ghist_o | output | 12 | Global history used |
| pred_lhist_o | output | 10 | Local history used |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_gctr_i | input | 2 | Returned global counter |
| upd_lctr_i | input | 2 | Returned local counter |
| upd_cctr_i | input | 2 | Returned chooser counter |
| upd_ghist_i | input | 12 | Returned global history |
| upd_lhist_i | input | 10 | Returned local history |

## Verification
Two functions can act on the global history on the same edge: the speculative shift from a result leaving the block, and a repair from a mispredicted update. The bench arranges this on purpose. It issues a second prediction so that its result appears in the very cycle in which the update of an earlier mispredicted branch is presented. The next prediction's `pred_ghist_o` must then equal the repaired value, and the speculative bit of the second branch must not appear in it. A reference model kept in the bench predicts every returned counter and history across loop-like, alternating, aliased-PC, saturating and pseudo-random outcome streams.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT = 2'b01;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/tp_ram.sv
module tp_ram #(
  parameter int            AW   = 10,
  parameter int            DW   = 2,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          clr_done
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] clr_addr;
  logic          clr_busy;
  logic          we;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;

  // clearing sweep, one entry per cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_addr <= '0;
      clr_busy <= 1'b1;
    end else if (clr_busy) begin
      clr_addr <= clr_addr + 1'b1;
      if (clr_addr == '1) clr_busy <= 1'b0;
    end
  end

  always_comb begin
    if (clr_busy) begin
      we = 1'b1;
      wa = clr_addr;
      wd = INIT;
    end else begin
      we = wr_en;
      wa = wr_addr;
      wd = wr_data;
    end
  end

  // plain dual-port array with registered read
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_data <= mem[rd_addr];
  end

  assign clr_done = !clr_busy;

  assert_clear_stays_done_R1: assert property (@(posedge clk) disable iff (rst)
    clr_done |=> clr_done);
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int GW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spec_en,
  input  logic          spec_bit,
  input  logic          fix_en,
  input  logic [GW-1:0] fix_hist,
  input  logic          fix_bit,
  output logic [GW-1:0] hist
);
  logic unused_fix_top;
  assign unused_fix_top = fix_hist[GW-1];

  always_ff @(posedge clk) begin
    if (rst)          hist <= '0;
    else if (fix_en)  hist <= {fix_hist[GW-2:0], fix_bit};
    else if (spec_en) hist <= {hist[GW-2:0], spec_bit};
  end

  assert_repair_wins_R9: assert property (@(posedge clk) disable iff (rst)
    fix_en |=> hist == {$past(fix_hist[GW-2:0]), $past(fix_bit)});

  assert_spec_shift_R8: assert property (@(posedge clk) disable iff (rst)
    (spec_en && !fix_en) |=> hist == {$past(hist[GW-2:0]), $past(spec_bit)});

  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!spec_en && !fix_en) |=> $stable(hist));
endmodule

// File: rtl/tp_train.sv
module tp_train
  import tp_pkg::*;
(
  input  logic  taken,
  input  ctr2_t gctr,
  input  ctr2_t lctr,
  input  ctr2_t cctr,
  output ctr2_t g_next,
  output ctr2_t l_next,
  output ctr2_t c_next,
  output logic  c_wr,
  output logic  mispredict
);
  logic gdir, ldir, fdir;

  always_comb begin
    gdir       = gctr[1];
    ldir       = lctr[1];
    fdir       = cctr[1] ? gdir : ldir;
    mispredict = (fdir != taken);
    g_next     = ctr_step(gctr, taken);
    l_next     = ctr_step(lctr, taken);
    c_wr       = (gdir != ldir);
    c_next     = ctr_step(cctr, gdir == taken);
  end

  always_comb begin
    assert_sat_top_R6: assert (!(gctr == 2'b11 && taken) || g_next == 2'b11);
    assert_sat_bottom_R6: assert (!(lctr == 2'b00 && !taken) || l_next == 2'b00);
    assert_chooser_up_R7: assert (!(c_wr && gdir == taken && cctr != 2'b11)
                                  || c_next == cctr + 2'd1);
  end
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import tp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int GH_W   = 12,
  parameter int LHT_AW = 10,
  parameter int LH_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready_o,
  input  logic              pred_valid_i,
  input  logic [PC_W-1:0]   pred_pc_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic [1:0]        pred_gctr_o,
  output logic [1:0]        pred_lctr_o,
  output logic [1:0]        pred_cctr_o,
  output logic [GH_W-1:0]   pred_ghist_o,
  output logic [LH_W-1:0]   pred_lhist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [1:0]        upd_gctr_i,
  input  logic [1:0]        upd_lctr_i,
  input  logic [1:0]        upd_cctr_i,
  input  logic [GH_W-1:0]   upd_ghist_i,
  input  logic [LH_W-1:0]   upd_lhist_i
);
  localparam int IDX_HI  = PC_LSB + LHT_AW;
  localparam int N_TABLE = 4;

  logic [N_TABLE-1:0] tbl_done;
  logic [GH_W-1:0]    ghr;

  // predict pipeline
  logic              s1_valid, s2_valid;
  logic [GH_W-1:0]   s1_ghist, s2_ghist;
  logic [LH_W-1:0]   s2_lhist;
  ctr2_t             s2_gctr, s2_cctr;
  logic [LH_W-1:0]   lht_q;
  ctr2_t             gpht_q, ch_q, lpht_q;

  // update path
  ctr2_t g_next, l_next, c_next;
  logic  c_wr, mispredict;
  logic [LHT_AW-1:0] pred_idx, upd_idx;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc_i[PC_W-1:IDX_HI], pred_pc_i[PC_LSB-1:0],
                            upd_pc_i[PC_W-1:IDX_HI], upd_pc_i[PC_LSB-1:0]};

  assign pred_idx = pred_pc_i[PC_LSB +: LHT_AW];
  assign upd_idx  = upd_pc_i[PC_LSB +: LHT_AW];
  assign ready_o  = &tbl_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s1_valid <= pred_valid_i & ready_o;
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    s1_ghist <= ghr;
    s2_ghist <= s1_ghist;
    s2_lhist <= lht_q;
    s2_gctr  <= gpht_q;
    s2_cctr  <= ch_q;
  end

  // local history table: per-branch histories
  tp_ram #(.AW(LHT_AW), .DW(LH_W), .INIT('0)) u_lht (
    .clk(clk), .rst(rst),
    .rd_addr(pred_idx), .rd_data(lht_q),
    .wr_en(upd_valid_i), .wr_addr(upd_idx),
    .wr_data({upd_lhist_i[LH_W-2:0], upd_taken_i}),
    .clr_done(tbl_done[0])
  );

  // local pattern counters, addressed by the history just read
  tp_ram #(.AW(LH_W), .DW(2), .INIT(CTR_WEAK_NT)) u_lpht (
    .clk(clk), .rst(rst),
    .rd_addr(lht_q), .rd_data(lpht_q),
    .wr_en(upd_valid_i), .wr_addr(upd_lhist_i), .wr_data(l_next),
    .clr_done(tbl_done[1])
  );

  // global pattern counters
  tp_ram #(.AW(GH_W), .DW(2), .INIT(CTR_WEAK_NT)) u_gpht (
    .clk(clk), .rst(rst),
    .rd_addr(ghr), .rd_data(gpht_q),
    .wr_en(upd_valid_i), .wr_addr(upd_ghist_i), .wr_data(g_next),
    .clr_done(tbl_done[2])
  );

  // chooser counters, MSB set selects the global side
  tp_ram #(.AW(GH_W), .DW(2), .INIT(CTR_WEAK_NT)) u_choose (
    .clk(clk), .rst(rst),
    .rd_addr(ghr), .rd_data(ch_q),
    .wr_en(upd_valid_i & c_wr), .wr_addr(upd_ghist_i), .wr_data(c_next),
    .clr_done(tbl_done[3])
  );

  tp_train u_train (
    .taken(upd_taken_i),
    .gctr(upd_gctr_i), .lctr(upd_lctr_i), .cctr(upd_cctr_i),
    .g_next(g_next), .l_next(l_next), .c_next(c_next),
    .c_wr(c_wr), .mispredict(mispredict)
  );

  tp_ghist #(.GW(GH_W)) u_ghist (
    .clk(clk), .rst(rst),
    .spec_en(s2_valid), .spec_bit(pred_taken_o),
    .fix_en(upd_valid_i & mispredict), .fix_hist(upd_ghist_i), .fix_bit(upd_taken_i),
    .hist(ghr)
  );

  assign pred_valid_o = s2_valid;
  assign pred_gctr_o  = s2_gctr;
  assign pred_lctr_o  = lpht_q;
  assign pred_cctr_o  = s2_cctr;
  assign pred_ghist_o = s2_ghist;
  assign pred_lhist_o = s2_lhist;
  assign pred_taken_o = s2_cctr[1] ? s2_gctr[1] : lpht_q[1];

  assert_result_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (pred_valid_i && ready_o) |=> ##1 pred_valid_o);

  assert_no_result_busy_R2: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> !pred_valid_o);

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);
endmodule

// File: tb/tourney_bp_tb_top.sv
module tourney_bp_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int GH  = 12;
  localparam int LA  = 10;
  localparam int LH  = 10;
  localparam int PCW = 32;

  typedef struct packed {
    logic          taken;
    logic [1:0]    g;
    logic [1:0]    l;
    logic [1:0]    c;
    logic [GH-1:0] gh;
    logic [LH-1:0] lh;
    int            due;
  } pred_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst = 1'b1;
  logic           ready_o;
  logic           pred_valid_i = 1'b0;
  logic [PCW-1:0] pred_pc_i = '0;
  logic           pred_valid_o, pred_taken_o;
  logic [1:0]     pred_gctr_o, pred_lctr_o, pred_cctr_o;
  logic [GH-1:0]  pred_ghist_o;
  logic [LH-1:0]  pred_lhist_o;
  logic           upd_valid_i = 1'b0;
  logic [PCW-1:0] upd_pc_i = '0;
  logic           upd_taken_i = 1'b0;
  logic [1:0]     upd_gctr_i = '0, upd_lctr_i = '0, upd_cctr_i = '0;
  logic [GH-1:0]  upd_ghist_i = '0;
  logic [LH-1:0]  upd_lhist_i = '0;

  tourney_bp dut_i (
    .clk(clk), .rst(rst), .ready_o(ready_o),
    .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
    .pred_gctr_o(pred_gctr_o), .pred_lctr_o(pred_lctr_o), .pred_cctr_o(pred_cctr_o),
    .pred_ghist_o(pred_ghist_o), .pred_lhist_o(pred_lhist_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_gctr_i(upd_gctr_i), .upd_lctr_i(upd_lctr_i), .upd_cctr_i(upd_cctr_i),
    .upd_ghist_i(upd_ghist_i), .upd_lhist_i(upd_lhist_i)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit first_seen = 1'b0;
  pred_t exp_q[$];

  // reference model state
  logic [1:0]    m_g   [1 << GH];
  logic [1:0]    m_c   [1 << GH];
  logic [1:0]    m_lp  [1 << LH];
  logic [LH-1:0] m_lht [1 << LA];
  logic [GH-1:0] m_ghr;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  // monitor: pop and compare every result
  always @(negedge clk) begin
    if (!rst && pred_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 result without request", 1, 0);
      end else begin
        pred_t e;
        e = exp_q.pop_front();
        chk(cyc == e.due, "R2 result latency", cyc, e.due);
        chk(pred_taken_o == e.taken, "R3 final direction", pred_taken_o, e.taken);
        chk(pred_gctr_o == e.g, "R4 R6 global counter", pred_gctr_o, e.g);
        chk(pred_lctr_o == e.l, "R5 R6 local counter", pred_lctr_o, e.l);
        chk(pred_cctr_o == e.c, "R7 chooser counter", pred_cctr_o, e.c);
        chk(pred_ghist_o == e.gh, "R8 R9 global history", pred_ghist_o, e.gh);
        chk(pred_lhist_o == e.lh, "R10 local history", pred_lhist_o, e.lh);
        if (!first_seen) begin
          first_seen = 1'b1;
          chk(pred_gctr_o == 2'b01 && pred_lctr_o == 2'b01 && pred_cctr_o == 2'b01
              && pred_ghist_o == '0 && pred_lhist_o == '0 && !pred_taken_o,
              "R1 cleared tables", {pred_gctr_o, pred_lctr_o, pred_cctr_o}, 6'b010101);
        end
      end
    end
  end

  // driver: compute expectation, push it, present the request
  task automatic do_predict(input logic [PCW-1:0] pc, output pred_t e);
    logic [LA-1:0] li;
    li      = pc[2 +: LA];
    e.lh    = m_lht[li];
    e.l     = m_lp[e.lh];
    e.g     = m_g[m_ghr];
    e.c     = m_c[m_ghr];
    e.gh    = m_ghr;
    e.taken = e.c[1] ? e.g[1] : e.l[1];
    m_ghr   = {m_ghr[GH-2:0], e.taken};
    @(posedge clk); #1;
    pred_valid_i = 1'b1;
    pred_pc_i    = pc;
    @(posedge clk); #1;
    pred_valid_i = 1'b0;
    e.due = cyc + 1;
    exp_q.push_back(e);
  endtask

  task automatic do_update(input logic [PCW-1:0] pc, input pred_t e, input logic t);
    @(posedge clk); #1;
    upd_valid_i = 1'b1;
    upd_pc_i    = pc;
    upd_taken_i = t;
    upd_gctr_i  = e.g;
    upd_lctr_i  = e.l;
    upd_cctr_i  = e.c;
    upd_ghist_i = e.gh;
    upd_lhist_i = e.lh;
    @(posedge clk); #1;
    upd_valid_i = 1'b0;
    m_g[e.gh] = step2(e.g, t);
    m_lp[e.lh] = step2(e.l, t);
    if (e.g[1] != e.l[1]) m_c[e.gh] = step2(e.c, e.g[1] == t);
    m_lht[pc[2 +: LA]] = {e.lh[LH-2:0], t};
    if (t != e.taken) m_ghr = {e.gh[GH-2:0], t};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic run(input logic [PCW-1:0] pc, input logic t);
    pred_t e;
    do_predict(pc, e);
    idle(2);
    do_update(pc, e, t);
    idle(1);
  endtask

  // repair and speculative shift on the same edge (R9)
  task automatic collide(input logic [PCW-1:0] pca, input logic [PCW-1:0] pcb);
    pred_t ea, eb;
    do_predict(pca, ea);
    idle(2);
    do_predict(pcb, eb);
    do_update(pca, ea, !ea.taken);
    idle(2);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < (1 << GH); i++) begin m_g[i] = 2'b01; m_c[i] = 2'b01; end
    for (int i = 0; i < (1 << LH); i++) m_lp[i] = 2'b01;
    for (int i = 0; i < (1 << LA); i++) m_lht[i] = '0;
    m_ghr = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready_o == 1'b0, "R1 ready low in reset", ready_o, 0);
    chk(pred_valid_o == 1'b0, "R2 no result in reset", pred_valid_o, 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // request during clearing must be dropped (R2)
    idle(4);
    chk(ready_o == 1'b0, "R1 ready low while clearing", ready_o, 0);
    pred_valid_i = 1'b1;
    pred_pc_i    = 32'h40;
    @(posedge clk); #1;
    pred_valid_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(pred_valid_o == 1'b0, "R2 busy request ignored", pred_valid_o, 0);
    end

    while (!ready_o) @(posedge clk);
    #1;
    chk(ready_o == 1'b1, "R1 ready after clearing", ready_o, 1);

    // loop-shaped branch: three taken then one not-taken (R5 R10)
    for (int i = 0; i < 60; i++) run(32'h100, (i % 4) != 3);
    // alternating branch
    for (int i = 0; i < 40; i++) run(32'h240, i[0]);
    // always-taken branch drives counters to saturation (R6)
    for (int i = 0; i < 30; i++) run(32'h380, 1'b1);
    // PCs sharing index bits [11:2] alias in the history table (R5)
    for (int i = 0; i < 20; i++) begin
      run(32'h0000_0010, 1'b0);
      run(32'h0000_1010, 1'b1);
    end
    // repair colliding with speculative shift (R9)
    for (int i = 0; i < 6; i++) collide(32'h500 + 32'(i * 4), 32'h700 + 32'(i * 8));
    // pseudo-random outcomes over several branches
    lfsr = 16'hACE1;
    for (int i = 0; i < 160; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run(32'h800 + {26'd0, lfsr[2:0], 3'b000}, lfsr[5]);
    end
    collide(32'h904, 32'h908);
    run(32'h90c, 1'b1);

    idle(4);
    chk(exp_q.size() == 0, "R2 all results returned", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule